// File: doc/BRIEF.md
# Serial Transmitter with Break Header

This block is the transmit half of an asynchronous serial port. Characters of 8 or 9 bits are written into a four-entry queue. A state machine takes them one at a time into a shift register and sends each one on a single line. A frame is a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. All bit timing comes from a programmable divider. One bit lasts 16 baud ticks, and a tick occurs every `divisor+1` clock cycles.

The block can also open a bus frame with a header. Software first sets the break request with `brk_set`. The next accepted write is then a placeholder: its value is discarded and it queues a break. The break holds the line low for 13 bit times and is followed by a single high stop bit. The write after the placeholder, normally 0x55, is queued as the sync character and goes out right behind the break. The hardware clears the break request once the break and its stop bit are done.

The state machine has seven states. IDLE holds the line high with nothing loaded. ARM holds a loaded character until the first baud tick. START, DATA, PARITY and STOP send the parts of a character frame. BREAK holds the line low. The transitions are:
- IDLE to ARM (load) when the queue is not empty and transmit has been enabled for at least one cycle.
- ARM to START, or ARM to BREAK for a break entry, on the next tick.
- START to DATA after one bit time.
- DATA to PARITY, or DATA to STOP, after the last data bit.
- PARITY to STOP after one bit time.
- BREAK to STOP after 13 bit times.
- STOP stays in STOP for a second stop bit when two stop bits are set and the entry is not a break.
- STOP to START or STOP to BREAK (chained load) when another entry is waiting.
- STOP to IDLE otherwise.

Top module: `sertx_core`

## Requirements
- R1: The line idles high. Each character is a low start bit, then the data bits least significant first, then the parity bit if enabled, then one stop bit (`two_stop`=0) or two stop bits (`two_stop`=1), all high. Every bit lasts 16*(`divisor`+1) clock cycles.
- R2: Parity is sent only when `nine_bit`=0. `parity_mode` 2'b01 gives even parity over the 8 data bits, and 2'b10 gives odd parity. Values 2'b00 and 2'b11 send no parity bit.
- R3: The queue holds 4 entries, and entries are sent in write order. `fifo_full` is high when it holds 4 entries and `fifo_empty` is high when it holds none. A write made while `fifo_full` is high is dropped, even if an entry leaves the queue in the same cycle.
- R4: With `nine_bit`=1, only word writes (`wr_word`=1) are accepted and all 9 bits of `wr_data` are sent; byte writes are dropped. With `nine_bit`=0, `wr_data[7:0]` is sent.
- R5: Entries written while `tx_en`=0 stay queued and the line stays high. The baud divider is cleared while `tx_en`=0. After `tx_en` rises, the start bit begins within 2*(`divisor`+1)+3 cycles.
- R6: A rising edge of `tx_en` gives a one-cycle `tx_irq` pulse in the following cycle.
- R7: With `irq_sel`=0, `tx_irq` pulses once for every entry that leaves the queue. With `irq_sel`=1, it pulses once each time the shift path becomes idle.
- R8: While the break request is pending and not yet used, the next accepted write queues a break, and its data value is ignored. A break is 13 bit times low followed by one high stop bit.
- R9: The write accepted after the placeholder is sent as a normal character directly after the break's stop bit.
- R10: `brk_set` sets `brk_pending`. The hardware clears `brk_pending` in the cycle after the break's stop bit ends.
- R11: `sr_empty` is high exactly when no character or break is loaded or being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; the baud divider runs only while this is high |
| brk_set | input | 1 | Pulse that sets the break request |
| wr_en | input | 1 | Write strobe into the queue |
| wr_word | input | 1 | 1 = word write, 0 = byte write |
| wr_data | input | 9 | Character to queue |
| divisor | input | DIV_W | Baud divider; tick period is divisor+1 cycles |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| parity_mode | input | 2 | 01 even, 10 odd, other values none |
| two_stop | input | 1 | 1 = two stop bits |
| irq_sel | input | 1 | 0 = interrupt per entry taken, 1 = interrupt when idle |
| tx_out | output | 1 | Serial line |
| brk_pending | output | 1 | Break request, cleared by hardware |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_empty | output | 1 | Queue holds no entry |
| sr_empty | output | 1 | Shift path idle |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
Two things can happen in the same clock cycle: a new write can land while the state machine takes an entry out of the queue, either from IDLE or from the chained load at the end of STOP. The bench provokes this with random bursts of writes, one per cycle, that fill the queue while characters are being sent. It decides whether each write is accepted only from the `fifo_full` level it sees before the edge. The characters decoded from the line must then match that accepted sequence exactly, with no entry lost or duplicated. The count of interrupt pulses must match the number of entries taken.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } tx_state_e;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    typedef struct packed {
        logic       brk;
        logic [8:0] data;
    } tx_entry_t;

endpackage

// File: rtl/sertx_baud.sv
`timescale 1ns/1ps
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == divisor) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == divisor);

    // Divider starts from zero when transmit is enabled
    assert_clear_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/sertx_fifo.sv
`timescale 1ns/1ps
module sertx_fifo
    import sertx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  tx_entry_t wdata,
    input  logic      pop,
    output tx_entry_t rdata,
    output logic      full,
    output logic      empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    tx_entry_t          mem_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]   count_q;
    logic               do_push, do_pop;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_ptr_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    assert_pop_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/sertx_shifter.sv
`timescale 1ns/1ps
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int OVS        = 16,
    parameter int BREAK_BITS = 13
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load_ok,
    input  logic      ent_valid,
    input  tx_entry_t ent,
    input  logic      nine_bit,
    input  logic [1:0] parity_mode,
    input  logic      two_stop,
    output logic      pop,
    output logic      tx_out,
    output logic      sr_empty,
    output logic      brk_done
);
    localparam int SUB_W = $clog2(OVS);
    localparam int BIT_W = $clog2(BREAK_BITS + 1);

    tx_state_e         state_q, state_d;
    logic [SUB_W-1:0]  sub_q, sub_d;
    logic [BIT_W-1:0]  bitn_q, bitn_d;
    logic [8:0]        shreg_q, shreg_d;
    logic              par_q, par_d;
    logic              brk_q, brk_d;
    logic              nine_q, nine_d;
    logic              pen_q, pen_d;
    logic              two_q, two_d;
    logic              end_bit, can_load, take;
    logic [BIT_W-1:0]  last_data;

    assign end_bit   = tick && (sub_q == SUB_W'(OVS - 1));
    assign can_load  = load_ok && ent_valid;
    assign last_data = nine_q ? BIT_W'(8) : BIT_W'(7);

    // Next-state and datapath
    always_comb begin
        state_d  = state_q;
        sub_d    = sub_q;
        bitn_d   = bitn_q;
        shreg_d  = shreg_q;
        par_d    = par_q;
        brk_d    = brk_q;
        nine_d   = nine_q;
        pen_d    = pen_q;
        two_d    = two_q;
        take     = 1'b0;
        brk_done = 1'b0;

        if (tick && state_q != ST_IDLE && state_q != ST_ARM) begin
            sub_d = (sub_q == SUB_W'(OVS - 1)) ? '0 : sub_q + 1'b1;
        end

        unique case (state_q)
            ST_IDLE: begin
                if (can_load) begin
                    take    = 1'b1;
                    state_d = ST_ARM;
                end
            end
            ST_ARM: begin
                if (tick) begin
                    state_d = brk_q ? ST_BREAK : ST_START;
                    sub_d   = '0;
                    bitn_d  = '0;
                end
            end
            ST_START: begin
                if (end_bit) begin
                    state_d = ST_DATA;
                    bitn_d  = '0;
                end
            end
            ST_DATA: begin
                if (end_bit) begin
                    shreg_d = {1'b0, shreg_q[8:1]};
                    if (bitn_q == last_data) begin
                        state_d = pen_q ? ST_PARITY : ST_STOP;
                        bitn_d  = '0;
                    end else begin
                        bitn_d = bitn_q + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (end_bit) begin
                    state_d = ST_STOP;
                    bitn_d  = '0;
                end
            end
            ST_STOP: begin
                if (end_bit) begin
                    if (!brk_q && two_q && bitn_q == '0) begin
                        bitn_d = BIT_W'(1);
                    end else begin
                        brk_done = brk_q;
                        bitn_d   = '0;
                        if (can_load) begin
                            take    = 1'b1;
                            state_d = ent.brk ? ST_BREAK : ST_START;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            ST_BREAK: begin
                if (end_bit) begin
                    if (bitn_q == BIT_W'(BREAK_BITS - 1)) begin
                        state_d = ST_STOP;
                        bitn_d  = '0;
                    end else begin
                        bitn_d = bitn_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (take) begin
            shreg_d = ent.data;
            brk_d   = ent.brk;
            nine_d  = nine_bit;
            two_d   = two_stop;
            pen_d   = !nine_bit && (parity_mode == PAR_EVEN || parity_mode == PAR_ODD);
            par_d   = (parity_mode == PAR_ODD) ? ~^ent.data[7:0] : ^ent.data[7:0];
            sub_d   = '0;
        end
    end

    assign pop = take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sub_q   <= '0;
            bitn_q  <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            brk_q   <= 1'b0;
            nine_q  <= 1'b0;
            pen_q   <= 1'b0;
            two_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sub_q   <= sub_d;
            bitn_q  <= bitn_d;
            shreg_q <= shreg_d;
            par_q   <= par_d;
            brk_q   <= brk_d;
            nine_q  <= nine_d;
            pen_q   <= pen_d;
            two_q   <= two_d;
        end
    end

    // Outputs
    always_comb begin
        sr_empty = (state_q == ST_IDLE);
        unique case (state_q)
            ST_START, ST_BREAK: tx_out = 1'b0;
            ST_DATA:            tx_out = shreg_q[0];
            ST_PARITY:          tx_out = par_q;
            default:            tx_out = 1'b1;
        endcase
    end

    // Line and state move only on baud ticks once a frame runs
    assert_tick_paced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state_q != ST_IDLE && state_q != ST_ARM) |=> ($stable(state_q) && $stable(tx_out)));

    assert_arm_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && !tick) |=> (state_q == ST_ARM));

    assert_break_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BREAK && !end_bit) |=> (state_q == ST_BREAK && !tx_out));

endmodule

// File: rtl/sertx_core.sv
`timescale 1ns/1ps
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int DIV_W      = 16,
    parameter int OVS        = 16,
    parameter int BREAK_BITS = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             brk_set,
    input  logic             wr_en,
    input  logic             wr_word,
    input  logic [8:0]       wr_data,
    input  logic [DIV_W-1:0] divisor,
    input  logic             nine_bit,
    input  logic [1:0]       parity_mode,
    input  logic             two_stop,
    input  logic             irq_sel,
    output logic             tx_out,
    output logic             brk_pending,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             sr_empty,
    output logic             tx_irq
);
    logic      tick, pop, brk_done, wr_ok, arm_now;
    logic      tx_en_q, sr_empty_q, brk_armed_q;
    tx_entry_t wr_ent, rd_ent;

    assign wr_ok   = wr_en && (!nine_bit || wr_word);
    assign arm_now = wr_ok && !fifo_full && brk_pending && !brk_armed_q;

    always_comb begin
        wr_ent.brk  = brk_pending && !brk_armed_q;
        wr_ent.data = nine_bit ? wr_data : {1'b0, wr_data[7:0]};
    end

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tx_en),
        .divisor (divisor),
        .tick    (tick)
    );

    sertx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_ok),
        .wdata (wr_ent),
        .pop   (pop),
        .rdata (rd_ent),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    sertx_shifter #(.OVS(OVS), .BREAK_BITS(BREAK_BITS)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .load_ok     (tx_en && tx_en_q),
        .ent_valid   (!fifo_empty),
        .ent         (rd_ent),
        .nine_bit    (nine_bit),
        .parity_mode (parity_mode),
        .two_stop    (two_stop),
        .pop         (pop),
        .tx_out      (tx_out),
        .sr_empty    (sr_empty),
        .brk_done    (brk_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q     <= 1'b0;
            sr_empty_q  <= 1'b1;
            brk_pending <= 1'b0;
            brk_armed_q <= 1'b0;
            tx_irq      <= 1'b0;
        end else begin
            tx_en_q     <= tx_en;
            sr_empty_q  <= sr_empty;
            brk_pending <= brk_set || (brk_pending && !brk_done);
            brk_armed_q <= !brk_done && (brk_armed_q || arm_now);
            tx_irq      <= (tx_en && !tx_en_q) ||
                           (irq_sel ? (sr_empty && !sr_empty_q) : pop);
        end
    end

    assert_irq_on_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |=> tx_irq);

    assert_brk_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_pending) |-> $past(brk_done));

    assert_line_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sr_empty |-> tx_out);

endmodule

// File: tb/sertx_core_tb.sv
`timescale 1ns/1ps
module sertx_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, brk_set = 1'b0, wr_en = 1'b0, wr_word = 1'b0;
    logic [8:0]  wr_data = '0;
    logic [15:0] divisor = '0;
    logic        nine_bit = 1'b0, two_stop = 1'b0, irq_sel = 1'b0;
    logic [1:0]  parity_mode = 2'b00;
    logic        tx_out, brk_pending, fifo_full, fifo_empty, sr_empty, tx_irq;

    int checks = 0, errors = 0, irq_cnt = 0;
    int exp_q[$];
    int got_q[$];
    bit dec_on = 1'b0, brk_need = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    sertx_core u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_set(brk_set),
        .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .divisor(divisor),
        .nine_bit(nine_bit), .parity_mode(parity_mode), .two_stop(two_stop),
        .irq_sel(irq_sel), .tx_out(tx_out), .brk_pending(brk_pending),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .sr_empty(sr_empty),
        .tx_irq(tx_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bit_period();
        return 16 * (int'(divisor) + 1);
    endfunction

    function automatic bit par_on();
        return !nine_bit && (parity_mode == 2'b01 || parity_mode == 2'b10);
    endfunction

    function automatic bit exp_par(input bit [7:0] v);
        return (parity_mode == 2'b10) ? ~^v : ^v;
    endfunction

    always @(negedge clk) if (tx_irq) irq_cnt++;

    // Line decoder: mid-bit sampling from the falling edge
    initial begin : decoder
        int p, nb, lows;
        bit [8:0] v;
        bit pb;
        forever begin
            @(negedge clk);
            if (dec_on && tx_out === 1'b0) begin
                p  = bit_period();
                nb = nine_bit ? 9 : 8;
                repeat (p / 2 - 1) @(negedge clk);
                lows = 0;
                chk(tx_out == 1'b0, "R1 start", tx_out, 0);
                lows++;
                v = '0;
                for (int i = 0; i < nb; i++) begin
                    repeat (p) @(negedge clk);
                    v[i] = tx_out;
                    if (!tx_out) lows++;
                end
                pb = 1'b1;
                if (par_on()) begin
                    repeat (p) @(negedge clk);
                    pb = tx_out;
                    if (!pb) lows++;
                end
                repeat (p) @(negedge clk);
                if (tx_out) begin
                    if (par_on()) chk(pb == exp_par(v[7:0]), "R2 parity", pb, exp_par(v[7:0]));
                    if (two_stop) begin
                        repeat (p) @(negedge clk);
                        chk(tx_out == 1'b1, "R1 second stop", tx_out, 1);
                    end
                    got_q.push_back(int'(v));
                end else begin
                    lows++;
                    while (lows < 40) begin
                        repeat (p) @(negedge clk);
                        if (tx_out) break;
                        lows++;
                    end
                    chk(lows == 13, "R8 break length", lows, 13);
                    got_q.push_back(-1);
                end
            end
        end
    end

    task automatic wr(input int d, input bit w);
        bit ok;
        ok = !(nine_bit && !w) && !fifo_full;
        wr_en = 1'b1; wr_word = w; wr_data = 9'(d);
        if (ok) begin
            if (brk_need) begin
                exp_q.push_back(-1);
                brk_need = 1'b0;
            end else begin
                exp_q.push_back(nine_bit ? (d & 'h1FF) : (d & 'hFF));
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(fifo_empty && sr_empty));
        repeat (bit_period()) @(negedge clk);
    endtask

    task automatic cmp_stream(input string req);
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    endtask

    task automatic start_phase(input int dv, input bit nb, input bit [1:0] pm,
                               input bit ts, input bit sel);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        divisor = 16'(dv); nine_bit = nb; parity_mode = pm; two_stop = ts; irq_sel = sel;
        exp_q.delete(); got_q.delete(); irq_cnt = 0;
        @(negedge clk);
    endtask

    task automatic enable_and_check_irq();
        tx_en = 1'b1;
        @(negedge clk);
        chk(tx_irq == 1'b1, "R6 enable irq", tx_irq, 1);
    endtask

    task automatic check_irq_count();
        int e;
        if (irq_sel) e = 1 + ((exp_q.size() > 0) ? 1 : 0);
        else         e = 1 + exp_q.size();
        chk(irq_cnt == e, irq_sel ? "R7 idle irq" : "R7 per-entry irq", irq_cnt, e);
    endtask

    task automatic pulse_break();
        brk_set = 1'b1;
        @(negedge clk);
        brk_set = 1'b0;
        brk_need = 1'b1;
        @(negedge clk);
        chk(brk_pending == 1'b1, "R10 break set", brk_pending, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int cyc, n;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R11, R3, R10)
        chk(tx_out == 1'b1, "R1 reset idle line", tx_out, 1);
        chk(fifo_empty == 1'b1 && fifo_full == 1'b0, "R3 reset queue", fifo_empty, 1);
        chk(sr_empty == 1'b1, "R11 reset empty", sr_empty, 1);
        chk(brk_pending == 1'b0 && tx_irq == 1'b0, "R10 reset flags", brk_pending, 0);
        dec_on = 1'b1;

        // R5 / R3: preload while disabled, overfill, then enable
        start_phase(1, 1'b0, 2'b01, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) wr(8'h30 + i, 1'b0);
        chk(fifo_full == 1'b1, "R3 full after 4", fifo_full, 1);
        repeat (40) @(negedge clk);
        chk(tx_out == 1'b1 && !fifo_empty && sr_empty, "R5 held while disabled", tx_out, 1);
        tx_en = 1'b1;
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (tx_out && cyc < 100);
        chk(cyc <= 2 * (int'(divisor) + 1) + 3, "R5 prompt start", cyc, 2 * (int'(divisor) + 1) + 3);
        chk(sr_empty == 1'b0, "R11 busy while sending", sr_empty, 0);
        wait_idle();
        cmp_stream("R3 drop when full");
        check_irq_count();

        // R4: byte write dropped in 9-bit mode, word write carries bit 8
        start_phase(0, 1'b1, 2'b00, 1'b1, 1'b1);
        wr(9'h0AA, 1'b0);
        chk(fifo_empty == 1'b1, "R4 byte write dropped", fifo_empty, 1);
        wr(9'h1C3, 1'b1);
        chk(fifo_empty == 1'b0, "R4 word write taken", fifo_empty, 0);
        enable_and_check_irq();
        wait_idle();
        cmp_stream("R4 nine-bit stream");
        check_irq_count();

        // R8 R9 R10: break header, 8-bit, odd parity
        start_phase(1, 1'b0, 2'b10, 1'b1, 1'b0);
        enable_and_check_irq();
        pulse_break();
        wr(8'hA3, 1'b0);
        wr(8'h55, 1'b0);
        wr(8'h12, 1'b0);
        wait_idle();
        cmp_stream("R9 break then sync");
        chk(brk_pending == 1'b0, "R10 cleared by hardware", brk_pending, 1'b0);
        check_irq_count();

        // break header in 9-bit mode with idle interrupt
        start_phase(0, 1'b1, 2'b00, 1'b0, 1'b1);
        enable_and_check_irq();
        pulse_break();
        wr(9'h1FF, 1'b1);
        wr(9'h055, 1'b1);
        wait_idle();
        cmp_stream("R8 dummy ignored");
        chk(brk_pending == 1'b0, "R10 cleared nine-bit", brk_pending, 1'b0);
        check_irq_count();

        // random phases with back-to-back write bursts
        for (int ph = 0; ph < 12; ph++) begin
            start_phase(int'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                        2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)));
            enable_and_check_irq();
            n = int'($urandom_range(1, 7));
            for (int k = 0; k < n; k++)
                wr(int'($urandom_range(0, 511)), ($urandom_range(0, 3) != 0));
            wait_idle();
            cmp_stream("R1 random stream");
            check_irq_count();
        end

        tx_en = 1'b0;
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule